// File: doc/BRIEF.md
# Multi-Grant Exclusive Priority Picker

This block shares a small set of cache-buffer ports among a larger set of load/store request lines. Every cycle it looks at the whole request vector and hands out up to one grant per port. The grants are one-hot vectors that never share a bit, so no requester reaches two ports and no port carries two requesters. Port 0 takes the lowest-numbered pending request. Each further port takes the lowest-numbered request that the ports ahead of it left unclaimed.

Grants and per-port valid flags follow the request vector combinationally, in the same cycle. Each port's grant steers an AND-OR multiplexer that picks the address, byte mask and data of the chosen requester. That routed payload is registered, so it appears on the port outputs one clock edge later. A port that gets no grant registers all-zero payload. The default sizing has 16 request lines, which suits eight units with two request lines each (one of them kept for misaligned accesses), and 4 ports.

Top module: `mgrant_picker`

## Requirements
- R1: Each grant vector `grant_o[k*NUM_REQ +: NUM_REQ]` has at most one bit set.
- R2: No bit position is set in the grant vectors of two different ports in the same cycle.
- R3: Port k is granted the (k+1)-th lowest-numbered asserted bit of `req_i` (bit 0 is highest priority). Lower-numbered ports therefore always hold lower-numbered requesters.
- R4: The number of set bits in `valid_o` equals min(popcount(`req_i`), NUM_PORT), and the valid ports are always the lowest-numbered ones.
- R5: A grant bit is set only where the matching `req_i` bit is set.
- R6: `valid_o[k]` is 1 exactly when port k's grant vector is non-zero, in the same cycle as the request.
- R7: One clock edge after port k is granted requester i, `addr_o`, `mask_o` and `data_o` for port k equal requester i's `addr_i`, `mask_i` and `data_i` slices as sampled at that edge.
- R8: One clock edge after a cycle in which port k has no grant, its `addr_o`, `mask_o` and `data_o` slices are zero. This includes the case where no request is asserted.
- R9: While `rst_ni` is low, all payload outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NUM_REQ | Request lines, bit 0 highest priority |
| addr_i | input | NUM_REQ*ADDR_W | Per-requester address, requester i at slice i |
| mask_i | input | NUM_REQ*MASK_W | Per-requester byte mask |
| data_i | input | NUM_REQ*DATA_W | Per-requester data |
| grant_o | output | NUM_PORT*NUM_REQ | Per-port one-hot grant vectors, port k at slice k |
| valid_o | output | NUM_PORT | Per-port grant valid |
| addr_o | output | NUM_PORT*ADDR_W | Registered routed address per port |
| mask_o | output | NUM_PORT*MASK_W | Registered routed byte mask per port |
| data_o | output | NUM_PORT*DATA_W | Registered routed data per port |

## Verification
Grants and valid flags are due in the same cycle as the request pattern. The bench drives each pattern on the falling clock edge and compares `grant_o` and `valid_o` a nanosecond later, well before the next rising edge. Payloads are due one rising edge later, so the bench samples them two nanoseconds after that edge and checks them against the grants it predicted for the previous pattern. It does this before it drives the next pattern. Back-to-back patterns verify that a port drops to zero payload in the cycle after it loses its grant.

// File: rtl/mgp_pkg.sv
package mgp_pkg;
  localparam int unsigned NUM_REQ_D  = 16;
  localparam int unsigned NUM_PORT_D = 4;
  localparam int unsigned ADDR_W_D   = 32;
  localparam int unsigned DATA_W_D   = 64;

  function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/lsb_pick.sv
// Isolates the lowest set bit of a vector.
module lsb_pick #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] onehot_o
);
  assign onehot_o = vec_i & (~vec_i + W'(1));
endmodule

// File: rtl/pick_cascade.sv
module pick_cascade #(
  parameter int unsigned NUM_REQ  = 16,
  parameter int unsigned NUM_PORT = 4
) (
  input  logic [NUM_REQ-1:0]          req_i,
  output logic [NUM_PORT*NUM_REQ-1:0] grant_o
);
  logic [NUM_REQ-1:0] avail [NUM_PORT+1];
  assign avail[0] = req_i;

  for (genvar k = 0; k < NUM_PORT; k++) begin : g_stage
    logic [NUM_REQ-1:0] win;
    lsb_pick #(.W(NUM_REQ)) u_pick (
      .vec_i   (avail[k]),
      .onehot_o(win)
    );
    // remove this port's winner before the next stage looks
    assign avail[k+1] = avail[k] & ~win;
    assign grant_o[k*NUM_REQ +: NUM_REQ] = win;
  end
endmodule

// File: rtl/onehot_mux.sv
// AND-OR mux; zero output when select is all-zero.
module onehot_mux #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 104
) (
  input  logic [N-1:0]   sel_i,
  input  logic [N*W-1:0] data_i,
  output logic [W-1:0]   data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      data_o = data_o | (data_i[i*W +: W] & {W{sel_i[i]}});
    end
  end
endmodule

// File: rtl/mgrant_picker.sv
module mgrant_picker
  import mgp_pkg::*;
#(
  parameter int unsigned NUM_REQ  = NUM_REQ_D,
  parameter int unsigned NUM_PORT = NUM_PORT_D,
  parameter int unsigned ADDR_W   = ADDR_W_D,
  parameter int unsigned DATA_W   = DATA_W_D,
  parameter int unsigned MASK_W   = DATA_W / 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [NUM_REQ-1:0]           req_i,
  input  logic [NUM_REQ*ADDR_W-1:0]    addr_i,
  input  logic [NUM_REQ*MASK_W-1:0]    mask_i,
  input  logic [NUM_REQ*DATA_W-1:0]    data_i,
  output logic [NUM_PORT*NUM_REQ-1:0]  grant_o,
  output logic [NUM_PORT-1:0]          valid_o,
  output logic [NUM_PORT*ADDR_W-1:0]   addr_o,
  output logic [NUM_PORT*MASK_W-1:0]   mask_o,
  output logic [NUM_PORT*DATA_W-1:0]   data_o
);
  localparam int unsigned PAY_W = ADDR_W + MASK_W + DATA_W;

  logic [NUM_REQ*PAY_W-1:0] pay_flat;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_pack
    assign pay_flat[i*PAY_W +: PAY_W] = {addr_i[i*ADDR_W +: ADDR_W],
                                         mask_i[i*MASK_W +: MASK_W],
                                         data_i[i*DATA_W +: DATA_W]};
  end

  pick_cascade #(.NUM_REQ(NUM_REQ), .NUM_PORT(NUM_PORT)) u_cascade (
    .req_i  (req_i),
    .grant_o(grant_o)
  );

  for (genvar k = 0; k < NUM_PORT; k++) begin : g_port
    logic [NUM_REQ-1:0] sel;
    logic [PAY_W-1:0]   routed;
    logic [PAY_W-1:0]   pay_q;

    assign sel        = grant_o[k*NUM_REQ +: NUM_REQ];
    assign valid_o[k] = |sel;

    onehot_mux #(.N(NUM_REQ), .W(PAY_W)) u_mux (
      .sel_i (sel),
      .data_i(pay_flat),
      .data_o(routed)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pay_q <= '0;
      else         pay_q <= routed;
    end

    assign addr_o[k*ADDR_W +: ADDR_W] = pay_q[MASK_W+DATA_W +: ADDR_W];
    assign mask_o[k*MASK_W +: MASK_W] = pay_q[DATA_W +: MASK_W];
    assign data_o[k*DATA_W +: DATA_W] = pay_q[0 +: DATA_W];
  end
endmodule

// File: rtl/mgrant_picker_chk.sv
module mgrant_picker_chk #(
  parameter int unsigned NUM_REQ  = 16,
  parameter int unsigned NUM_PORT = 4,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned MASK_W   = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_REQ-1:0]          req_i,
  input logic [NUM_REQ*ADDR_W-1:0]   addr_i,
  input logic [NUM_REQ*MASK_W-1:0]   mask_i,
  input logic [NUM_REQ*DATA_W-1:0]   data_i,
  input logic [NUM_PORT*NUM_REQ-1:0] grant_o,
  input logic [NUM_PORT-1:0]         valid_o,
  input logic [NUM_PORT*ADDR_W-1:0]  addr_o,
  input logic [NUM_PORT*MASK_W-1:0]  mask_o,
  input logic [NUM_PORT*DATA_W-1:0]  data_o
);
  localparam int unsigned PAY_W = ADDR_W + MASK_W + DATA_W;

  logic [PAY_W-1:0] sel_pay [NUM_PORT];
  int unsigned      exp_cnt;

  always_comb begin
    for (int k = 0; k < NUM_PORT; k++) begin
      sel_pay[k] = '0;
      for (int i = 0; i < NUM_REQ; i++) begin
        if (grant_o[k*NUM_REQ+i])
          sel_pay[k] = sel_pay[k] | {addr_i[i*ADDR_W +: ADDR_W],
                                     mask_i[i*MASK_W +: MASK_W],
                                     data_i[i*DATA_W +: DATA_W]};
      end
    end
    exp_cnt = ($countones(req_i) < NUM_PORT) ? $countones(req_i) : NUM_PORT;
  end

  // R4
  valid_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(valid_o) == exp_cnt);

  // R9
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && mask_o == '0 && data_o == '0));

  for (genvar k = 0; k < NUM_PORT; k++) begin : g_k
    // R1
    onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o[k*NUM_REQ +: NUM_REQ]));
    // R5
    grant_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[k*NUM_REQ +: NUM_REQ] & ~req_i) == '0);
    // R7
    route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o[k] |=> {addr_o[k*ADDR_W +: ADDR_W], mask_o[k*MASK_W +: MASK_W],
                      data_o[k*DATA_W +: DATA_W]} == $past(sel_pay[k]));
    // R8
    idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o[k] |=> (addr_o[k*ADDR_W +: ADDR_W] == '0 &&
                       mask_o[k*MASK_W +: MASK_W] == '0 &&
                       data_o[k*DATA_W +: DATA_W] == '0));
    if (k > 0) begin : g_ord
      // R4
      valid_pack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[k] |-> valid_o[k-1]);
      // R3
      order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o[k] |-> grant_o[(k-1)*NUM_REQ +: NUM_REQ] < grant_o[k*NUM_REQ +: NUM_REQ]);
    end
    for (genvar b = k + 1; b < NUM_PORT; b++) begin : g_b
      // R2
      disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o[k*NUM_REQ +: NUM_REQ] & grant_o[b*NUM_REQ +: NUM_REQ]) == '0);
    end
  end
endmodule

bind mgrant_picker mgrant_picker_chk #(
  .NUM_REQ(NUM_REQ), .NUM_PORT(NUM_PORT), .ADDR_W(ADDR_W),
  .DATA_W(DATA_W), .MASK_W(MASK_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
  .mask_i(mask_i), .data_i(data_i), .grant_o(grant_o), .valid_o(valid_o),
  .addr_o(addr_o), .mask_o(mask_o), .data_o(data_o)
);

// File: tb/tb_mgrant_picker.sv
`timescale 1ns/1ps
module tb_mgrant_picker;
  localparam int NR = 16;
  localparam int NP = 4;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int MW = 8;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NR-1:0]     req_i = '0;
  logic [NR*AW-1:0]  addr_i;
  logic [NR*MW-1:0]  mask_i;
  logic [NR*DW-1:0]  data_i;
  logic [NP*NR-1:0]  grant_o;
  logic [NP-1:0]     valid_o;
  logic [NP*AW-1:0]  addr_o;
  logic [NP*MW-1:0]  mask_o;
  logic [NP*DW-1:0]  data_o;

  int tests = 0;
  int fails = 0;
  int salt  = 0;

  always #4 clk_i = ~clk_i;

  mgrant_picker dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .mask_i(mask_i), .data_i(data_i), .grant_o(grant_o), .valid_o(valid_o),
    .addr_o(addr_o), .mask_o(mask_o), .data_o(data_o)
  );

  function automatic logic [AW-1:0] a_of(int i, int s);
    return 32'hA000_0000 + 32'(i * 16) + 32'(s << 12);
  endfunction
  function automatic logic [MW-1:0] m_of(int i, int s);
    return 8'(i * 7 + s + 1);
  endfunction
  function automatic logic [DW-1:0] d_of(int i, int s);
    return {32'(32'hD000_0000 + s), 32'(i + 1)};
  endfunction

  task automatic load_payload(int s);
    for (int i = 0; i < NR; i++) begin
      addr_i[i*AW +: AW] = a_of(i, s);
      mask_i[i*MW +: MW] = m_of(i, s);
      data_i[i*DW +: DW] = d_of(i, s);
    end
  endtask

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Drives one pattern; checks grants this cycle and payload after the next edge.
  task automatic step(logic [NR-1:0] r);
    int idx [NP];
    logic [NR-1:0] left;
    int n;
    @(negedge clk_i);
    salt++;
    load_payload(salt);
    req_i = r;
    left = r;
    n = 0;
    for (int k = 0; k < NP; k++) begin
      idx[k] = -1;
      for (int i = 0; i < NR; i++) begin
        if (left[i] && idx[k] < 0) begin
          idx[k] = i;
          left[i] = 1'b0;
        end
      end
      if (idx[k] >= 0) n++;
    end
    #1;
    for (int k = 0; k < NP; k++) begin
      logic [NR-1:0] eg;
      eg = (idx[k] >= 0) ? (NR'(1) << idx[k]) : '0;
      chk("R3 grant", 256'(grant_o[k*NR +: NR]), 256'(eg));
      chk("R6 valid", 256'(valid_o[k]), 256'(idx[k] >= 0));
    end
    chk("R4 count", 256'($countones(valid_o)), 256'(n));
    @(posedge clk_i);
    #2;
    for (int k = 0; k < NP; k++) begin
      if (idx[k] >= 0) begin
        chk("R7 addr", 256'(addr_o[k*AW +: AW]), 256'(a_of(idx[k], salt)));
        chk("R7 mask", 256'(mask_o[k*MW +: MW]), 256'(m_of(idx[k], salt)));
        chk("R7 data", 256'(data_o[k*DW +: DW]), 256'(d_of(idx[k], salt)));
      end else begin
        chk("R8 zero", 256'({addr_o[k*AW +: AW], mask_o[k*MW +: MW], data_o[k*DW +: DW]}), 256'(0));
      end
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R9 addr", 256'(addr_o), 256'(0));
    chk("R9 mask", 256'(mask_o), 256'(0));
    chk("R9 data", 256'(data_o), 256'(0));
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic t_idle();       step(16'h0000); endtask
  task automatic t_single();     step(16'h0100); step(16'h8000); endtask
  task automatic t_partial();    step(16'h0205); endtask
  task automatic t_exact();      step(16'hF000); endtask
  // more than NP requests: R1/R2 disjoint one-hot, lowest four win
  task automatic t_overflow();   step(16'hFFFF); step(16'hAAAA); step(16'h8421 | 16'h0810); endtask
  task automatic t_drop();       step(16'h000F); step(16'h0001); step(16'h0000); endtask

  initial begin
    load_payload(0);
    t_reset();
    t_idle();
    t_single();
    t_partial();
    t_exact();
    t_overflow();
    t_drop();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    tests++;
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule